// File: doc/BRIEF.md
# Daughterboard Reference Clock Divider

This block lets the pin-0 line of each daughterboard I/O bank carry a clock divided down from the master clock, or leaves that line to ordinary general-purpose I/O. There is one bank for each side (transmit, receive) of each of the two daughterboard slots, so four banks by default. Each bank has its own 32-bit configuration word. Bit 7 of the word switches the divided clock on. Bits 6:0 set the half-period in master clock cycles. The upper bits are reserved.

Software writes a configuration word through a simple write strobe with a bank select. While a bank is enabled, its pin-0 output carries a square wave and its output enable is forced on. While a bank is disabled, the GPIO value and output enable for pin 0 pass through a register unchanged. Every output is registered.

Top module: `refclk_bank_array`

## Requirements
- R1: While `rst` is high, every `pin0_val` and `pin0_oe` bit is 0, and after reset every bank is disabled.
- R2: Suppose an accepted write sets bit 7 of bank b and either enables it from the disabled state or changes its divisor D (bits 6:0, nonzero). Count the write's clock edge as edge 0. After edge t (t >= 1), `pin0_val[b]` equals ((t-1)/D) mod 2, using integer division. The result is a square wave with period 2*D.
- R3: A divisor field of 0 behaves exactly like a divisor of 1, so the output toggles on every cycle.
- R4: While bank b is enabled, `pin0_oe[b]` is 1 whatever `gpio_oe_in[b]` is.
- R5: While bank b is disabled, `pin0_val[b]` and `pin0_oe[b]` after an edge equal `gpio_val_in[b]` and `gpio_oe_in[b]` as sampled at that edge.
- R6: A write reaches only the bank whose index equals `cfg_sel`, and only when `cfg_wr` is high. All other banks keep their configuration and their waveform phase.
- R7: Bits 31:8 of `cfg_wdata` have no effect. A word with junk in those bits acts the same as the word with them cleared.
- R8: Rewriting an enabled bank with the same enable and divisor does not disturb its waveform. A write that changes the divisor restarts the waveform from a low level at that write's edge.
- R9: A configuration write shows at the pins on the first edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (2) | Bank index for the write |
| cfg_wdata | input | 32 | Configuration word: bit 7 enable, bits 6:0 divisor, 31:8 reserved |
| gpio_val_in | input | NUM_BANKS | Pin-0 value from the ordinary GPIO logic, one bit per bank |
| gpio_oe_in | input | NUM_BANKS | Pin-0 output enable from the ordinary GPIO logic |
| pin0_val | output | NUM_BANKS | Final registered pin-0 value |
| pin0_oe | output | NUM_BANKS | Final registered pin-0 output enable |

## Verification
The bench keeps a phase-origin model for each bank. It predicts the wave from the edge of the restarting write, so the rise time and the half-period length are both pinned down. Directed cases cover these patterns:
- Small divisors and a zero divisor, which separate the 0-as-1 rule from an off-by-one count.
- A word with junk reserved bits, which shows whether decoding masks the upper bits.
- An identical rewrite followed by a divisor change, which separates a phase that keeps running from one that restarts.
- Toggling GPIO inputs while a bank is disabled, which separates passthrough from a stuck output.

Random writes to random banks, with random GPIO inputs on every cycle, then show whether each bank stays independent of the others.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int CFG_W  = 32;
  localparam int DIV_W  = 7;
  localparam int EN_POS = DIV_W;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
  } refclk_cfg_t;

  function automatic refclk_cfg_t decode_cfg(input logic [CFG_W-1:0] word);
    refclk_cfg_t c;
    c.en  = word[EN_POS];
    c.div = word[DIV_W-1:0];
    return c;
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction
endpackage

// File: rtl/refclk_cfg_reg.sv
module refclk_cfg_reg
  import refclk_pkg::*;
#(
  parameter int BANK_ID = 0,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  input  logic [CFG_W-1:0] wdata,
  output refclk_cfg_t      cfg_q,
  output logic             restart
);
  refclk_cfg_t nxt;
  logic        hit;

  always_comb begin
    hit     = wr && (sel == SEL_W'(BANK_ID));
    nxt     = decode_cfg(wdata);
    restart = hit && (nxt.div != cfg_q.div);
  end

  always_ff @(posedge clk) begin
    if (rst)      cfg_q <= '0;
    else if (hit) cfg_q <= nxt;
  end
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
  import refclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  always_comb last = eff_div(div) - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !en || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == last) begin
      cnt  <= '0;
      tick <= ~tick;
    end else begin
      cnt  <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/refclk_pin_mux.sv
module refclk_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic gpio_val,
  input  logic gpio_oe,
  output logic pin_val,
  output logic pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_val <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_val <= en ? tick : gpio_val;
      pin_oe  <= en ? 1'b1 : gpio_oe;
    end
  end
endmodule

// File: rtl/refclk_bank_array.sv
module refclk_bank_array
  import refclk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [NUM_BANKS-1:0] gpio_val_in,
  input  logic [NUM_BANKS-1:0] gpio_oe_in,
  output logic [NUM_BANKS-1:0] pin0_val,
  output logic [NUM_BANKS-1:0] pin0_oe
);
  logic [NUM_BANKS-1:0]       cfg_en_w;
  logic [NUM_BANKS*DIV_W-1:0] cfg_div_w;
  logic [NUM_BANKS-1:0]       tick_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    refclk_cfg_t cfg;
    logic        restart;

    refclk_cfg_reg #(.BANK_ID(b), .SEL_W(SEL_W)) u_cfg (
      .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
      .cfg_q(cfg), .restart(restart)
    );

    refclk_divider u_div (
      .clk(clk), .rst(rst), .en(cfg.en), .div(cfg.div),
      .restart(restart), .tick(tick_w[b])
    );

    refclk_pin_mux u_mux (
      .clk(clk), .rst(rst), .en(cfg.en), .tick(tick_w[b]),
      .gpio_val(gpio_val_in[b]), .gpio_oe(gpio_oe_in[b]),
      .pin_val(pin0_val[b]), .pin_oe(pin0_oe[b])
    );

    assign cfg_en_w[b]                  = cfg.en;
    assign cfg_div_w[b*DIV_W +: DIV_W]  = cfg.div;
  end
endmodule

// File: rtl/refclk_checker.sv
module refclk_checker
  import refclk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int SEL_W     = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfg_wr,
  input logic [SEL_W-1:0]           cfg_sel,
  input logic [CFG_W-1:0]           cfg_wdata,
  input logic [NUM_BANKS-1:0]       gpio_val_in,
  input logic [NUM_BANKS-1:0]       gpio_oe_in,
  input logic [NUM_BANKS-1:0]       pin0_val,
  input logic [NUM_BANKS-1:0]       pin0_oe,
  input logic [NUM_BANKS-1:0]       cfg_en,
  input logic [NUM_BANKS*DIV_W-1:0] cfg_div,
  input logic [NUM_BANKS-1:0]       tick
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_OE_FORCED: assert property (@(posedge clk) disable iff (rst)
      cfg_en[b] |=> pin0_oe[b]); // R4

    AST_GPIO_PASS: assert property (@(posedge clk) disable iff (rst)
      !cfg_en[b] |=> (pin0_val[b] == $past(gpio_val_in[b]) &&
                      pin0_oe[b]  == $past(gpio_oe_in[b]))); // R5

    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(cfg_wr && cfg_sel == SEL_W'(b)) |=>
        ($stable(cfg_en[b]) && $stable(cfg_div[b*DIV_W +: DIV_W]))); // R6

    AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && cfg_sel == SEL_W'(b)) |=>
        (cfg_en[b] == $past(cfg_wdata[EN_POS]) &&
         cfg_div[b*DIV_W +: DIV_W] == $past(cfg_wdata[DIV_W-1:0]))); // R7

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      !cfg_en[b] |=> !tick[b]); // R2
  end
endmodule

bind refclk_bank_array refclk_checker #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_refclk_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .gpio_val_in(gpio_val_in), .gpio_oe_in(gpio_oe_in),
  .pin0_val(pin0_val), .pin0_oe(pin0_oe),
  .cfg_en(cfg_en_w), .cfg_div(cfg_div_w), .tick(tick_w)
);

// File: tb/test_refclk_bank_array.sv
module test_refclk_bank_array;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int SW         = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_wr = 1'b0;
  logic [SW-1:0]   cfg_sel = '0;
  logic [31:0]     cfg_wdata = '0;
  logic [NB-1:0]   gpio_val_in = '0;
  logic [NB-1:0]   gpio_oe_in = '0;
  logic [NB-1:0]   pin0_val;
  logic [NB-1:0]   pin0_oe;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  string cur_tag = "";

  bit m_en  [NB];
  int m_div [NB];
  int m_org [NB];

  refclk_bank_array #(.NUM_BANKS(NB)) i_refclk_bank_array (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .gpio_val_in(gpio_val_in), .gpio_oe_in(gpio_oe_in),
    .pin0_val(pin0_val), .pin0_oe(pin0_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_wave(input int k, input int d);
    int e = (d == 0) ? 1 : d;
    return ((k / e) % 2) == 1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input int b);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s bank=%0d cyc=%0d actual=%0b expected=%0b", tag, b, cyc, act, exp);
    end
  endtask

  task automatic step(input bit wr, input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr      = wr;
    cfg_sel     = SW'(sel);
    cfg_wdata   = data;
    gpio_val_in = NB'($urandom);
    gpio_oe_in  = NB'($urandom);
    @(posedge clk);
    cyc++;
    #1;
    for (int b = 0; b < NB; b++) begin
      string t;
      if (m_en[b]) begin
        if (cur_tag != "")      t = cur_tag;
        else if (m_div[b] == 0) t = "R3";
        else if (cyc - m_org[b] == 1) t = "R9";
        else                    t = "R2";
        check(t, pin0_val[b], exp_wave(cyc - 1 - m_org[b], m_div[b]), b);
        check("R4", pin0_oe[b], 1'b1, b);
      end else begin
        t = (cur_tag != "") ? cur_tag : "R5";
        check(t, pin0_val[b], gpio_val_in[b], b);
        check("R5", pin0_oe[b], gpio_oe_in[b], b);
      end
    end
    if (wr) begin
      bit ne = data[7];
      int nd = int'(data[6:0]);
      if (ne && (!m_en[sel] || nd != m_div[sel])) m_org[sel] = cyc;
      m_en[sel]  = ne;
      m_div[sel] = nd;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int b = 0; b < NB; b++) begin m_en[b] = 0; m_div[b] = 0; m_org[b] = 0; end
    gpio_val_in = '1;
    gpio_oe_in  = '1;
    // R1: outputs held low during reset
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      for (int b = 0; b < NB; b++) begin
        check("R1", pin0_val[b], 1'b0, b);
        check("R1", pin0_oe[b], 1'b0, b);
      end
    end
    @(negedge clk) rst = 1'b0;
    cur_tag = "R1"; idle(4); cur_tag = "";

    // R2: divisor 3 on bank 0, R6: other banks stay passthrough
    step(1, 0, 32'h0000_0083); idle(20);
    // R3: divisor 0 on bank 1
    step(1, 1, 32'h0000_0080); idle(8);
    // R7: junk reserved bits, disabled word on bank 2 and enabled word on bank 3
    cur_tag = "R7";
    step(1, 2, 32'hABCD_EF05); idle(6);
    step(1, 3, 32'hFFFF_FF85); idle(24);
    cur_tag = "";
    // R8: identical rewrite keeps phase, then divisor change restarts
    cur_tag = "R8";
    step(1, 0, 32'h0000_0083); idle(7);
    step(1, 0, 32'h0000_0086); idle(26);
    cur_tag = "";
    // R5: disabling bank 1 hands the pin back
    step(1, 1, 32'h0000_0001); idle(10);
    // R6: write strobe low must not touch bank 2
    cur_tag = "R6";
    step(0, 2, 32'h0000_0082); idle(6);
    cur_tag = "";
    // large divisor
    step(1, 2, 32'h0000_00FF); idle(300);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) begin
        logic [31:0] w = $urandom;
        if ($urandom % 2) w[6:0] = 7'($urandom % 9);
        step(1, int'($urandom % NB), w);
      end else begin
        step(0, 0, 32'h0);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule